// File: doc/BRIEF.md
# Warp Lane Shuffle Network

This block exchanges data between the 32 lanes of one warp without any shared storage in the path. Each lane offers one 32-bit value. For each operation, every lane receives exactly one value read from some lane of the same group, and the operation's mode picks the rule that names that source lane. There are four rules. Indexed mode lets each lane name its own source, and several lanes may read the same one. Shift-up and shift-down move values by a common distance. Butterfly mode swaps values between lanes whose numbers differ in the bits of a mask.

A caller presents the packed value vector, the mode, the per-lane index vector or the common distance/mask operand, and raises `valid_in` for one cycle. On the next clock edge the block captures the exchanged vector in a register and raises `valid_out`. The register keeps that vector until the next accepted operation.

Top module: `lane_shuffle_net`

## Requirements
- R1: After a clock edge with `rst_n` low, `valid_out` is 0 and every bit of `values_out` is 0.
- R2: With mode 2'b00 (indexed), lane i receives the value of lane `lane_idx[8i+4:8i]`. Any number of lanes may name the same source lane.
- R3: In indexed mode, bits 7:5 of each lane's 8-bit index field have no effect on the result.
- R4: With mode 2'b01 (up), lane i receives lane i−n, where n is the unsigned 6-bit `operand`. When i−n < 0, lane i keeps its own value.
- R5: With mode 2'b10 (down), lane i receives lane i+n. When i+n > 31, lane i keeps its own value.
- R6: With mode 2'b11 (butterfly), lane i receives lane i XOR `operand[4:0]`. Bit 5 of `operand` has no effect in this mode.
- R7: `valid_out` equals `valid_in` of the previous clock edge. The exchanged vector appears on `values_out` in that same cycle.
- R8: While `valid_in` is low, `values_out` holds its value, whatever the other inputs do.

Lane i of `values_in` and `values_out` occupies bits [32i+31:32i]. Lane i's index occupies bits [8i+7:8i] of `lane_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Operation strobe |
| mode | input | 2 | 00 indexed, 01 up, 10 down, 11 butterfly |
| operand | input | 6 | Shift distance or butterfly mask |
| lane_idx | input | 256 | Per-lane source index, 8 bits per lane |
| values_in | input | 1024 | Lane values, 32 bits per lane |
| values_out | output | 1024 | Registered exchanged values |
| valid_out | output | 1 | Result valid, one cycle after `valid_in` |

## Verification
The bench builds the block with its default parameters: 32 lanes, 32-bit values, 8-bit index fields and a 6-bit operand. With these widths the index fields carry unused upper bits, and shift distances of 32 to 63 can be presented, so the bench can reach the ignored-bit cases and the out-of-range shift cases. Lane values are all distinct, so a wrong source lane always shows up as a wrong value. The stimulus table covers reversal, broadcast and scattered index patterns, shifts of 0, 1, 5, 31, 33 and 40, and butterfly masks with and without bit 5 set.

// File: rtl/shfl_pkg.sv
// Package: shared mode encoding for the lane shuffle network.
// Assumes a two-bit mode field on the operation.
package shfl_pkg;
    typedef enum logic [1:0] {
        SH_INDEXED = 2'b00,
        SH_UP      = 2'b01,
        SH_DOWN    = 2'b10,
        SH_BFLY    = 2'b11
    } shfl_mode_e;
endpackage

// File: rtl/shfl_src_sel.sv
// Module: shfl_src_sel
// Computes, for every lane, which lane it reads from under the current mode.
// Assumes LANES is a power of two and OP_W >= LANE_W. A shift whose source
// falls outside the group selects the lane itself.
module shfl_src_sel #(
    parameter int LANES  = 32,
    parameter int IDX_W  = 8,
    parameter int OP_W   = 6,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [1:0]             mode,
    input  logic [OP_W-1:0]        operand,
    input  logic [LANES*IDX_W-1:0] lane_idx,
    output logic [LANE_W-1:0]      src [LANES]
);
    import shfl_pkg::*;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Source lane rule for lane i.
        always_comb begin
            int n;
            n = int'(operand);
            src[i] = LANE_W'(i);
            case (shfl_mode_e'(mode))
                SH_INDEXED: src[i] = lane_idx[i*IDX_W +: LANE_W];
                SH_UP:      if (n <= i) src[i] = LANE_W'(i - n);
                SH_DOWN:    if (i + n < LANES) src[i] = LANE_W'(i + n);
                default:    src[i] = LANE_W'(i) ^ operand[LANE_W-1:0];
            endcase
        end
    end
endmodule

// File: rtl/shfl_xbar.sv
// Module: shfl_xbar
// Full any-to-any crossbar: each output lane takes the input lane named
// by its source index. Purely combinational.
module shfl_xbar #(
    parameter int LANES  = 32,
    parameter int DATA_W = 32,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [LANES*DATA_W-1:0] din,
    input  logic [LANE_W-1:0]       src [LANES],
    output logic [LANES*DATA_W-1:0] dout
);
    logic [DATA_W-1:0] lanes_in [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Unpack lane i of the input vector.
        assign lanes_in[i] = din[i*DATA_W +: DATA_W];
        // Pick the source value for output lane i.
        assign dout[i*DATA_W +: DATA_W] = lanes_in[src[i]];
    end
endmodule

// File: rtl/lane_shuffle_net.sv
// Module: lane_shuffle_net (top)
// Exchanges one value per lane across a warp under four source rules,
// then registers the result. valid_out follows valid_in by one cycle.
// The result register loads only on valid_in. Reset is synchronous, active low.
module lane_shuffle_net #(
    parameter int LANES  = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int OP_W   = 6,
    localparam int LANE_W = $clog2(LANES),
    localparam int VEC_W  = LANES * DATA_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valid_in,
    input  logic [1:0]             mode,
    input  logic [OP_W-1:0]        operand,
    input  logic [LANES*IDX_W-1:0] lane_idx,
    input  logic [VEC_W-1:0]       values_in,
    output logic [VEC_W-1:0]       values_out,
    output logic                   valid_out
);
    import shfl_pkg::*;

    logic [LANE_W-1:0] src [LANES];
    logic [VEC_W-1:0]  xbar_out;

    shfl_src_sel #(.LANES(LANES), .IDX_W(IDX_W), .OP_W(OP_W)) u_sel (
        .mode     (mode),
        .operand  (operand),
        .lane_idx (lane_idx),
        .src      (src)
    );

    shfl_xbar #(.LANES(LANES), .DATA_W(DATA_W)) u_xbar (
        .din  (values_in),
        .src  (src),
        .dout (xbar_out)
    );

    // Output register: capture the exchanged vector when an operation arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out  <= 1'b0;
            values_out <= '0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) values_out <= xbar_out;
        end
    end

    // R7: valid timing.
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
    a_r7_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);
    // R8: no operation, no change.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(values_out));
    // R4: lane 0 has no lower neighbour, so it keeps its value for every shift distance.
    a_r4_lane0_up: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && mode == SH_UP) |=>
        values_out[DATA_W-1:0] == $past(values_in[DATA_W-1:0]));
    // R5: the top lane has no upper neighbour, so it keeps its value for every shift distance.
    a_r5_top_down: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && mode == SH_DOWN) |=>
        values_out[VEC_W-1 -: DATA_W] == $past(values_in[VEC_W-1 -: DATA_W]));
    // R6: a zero mask leaves the vector unchanged.
    a_r6_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && mode == SH_BFLY && operand[LANE_W-1:0] == '0) |=>
        values_out == $past(values_in));
endmodule

// File: tb/tb_lane_shuffle_net.sv
module tb_lane_shuffle_net;
    localparam int L = 32, DW = 32, IW = 8, OW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid_in = 1'b0;
    logic [1:0] mode = '0;
    logic [OW-1:0] operand = '0;
    logic [L*IW-1:0] lane_idx = '0;
    logic [L*DW-1:0] values_in = '0;
    logic [L*DW-1:0] values_out;
    logic valid_out;

    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    lane_shuffle_net dut (.clk, .rst_n, .valid_in, .mode, .operand,
                          .lane_idx, .values_in, .values_out, .valid_out);

    typedef struct packed {
        logic [1:0] md;
        logic [5:0] op;
        logic [1:0] ipat;
        logic [7:0] seed;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{2'b00, 6'd0,  2'd0, 8'h11},  // reverse, upper bits set
        '{2'b00, 6'd0,  2'd1, 8'h22},  // broadcast lane 7
        '{2'b00, 6'd0,  2'd2, 8'h33},  // scattered, upper bits vary
        '{2'b01, 6'd1,  2'd3, 8'h44},
        '{2'b01, 6'd5,  2'd3, 8'h55},
        '{2'b01, 6'd0,  2'd3, 8'h66},
        '{2'b01, 6'd31, 2'd3, 8'h77},
        '{2'b01, 6'd40, 2'd3, 8'h88},  // out of range everywhere
        '{2'b10, 6'd3,  2'd3, 8'h99},
        '{2'b10, 6'd33, 2'd3, 8'hAA},  // out of range everywhere
        '{2'b10, 6'd31, 2'd3, 8'hBB},
        '{2'b11, 6'd1,  2'd3, 8'hCC},
        '{2'b11, 6'd31, 2'd3, 8'hDD},
        '{2'b11, 6'h25, 2'd3, 8'hEE}   // bit 5 set: mask is 5
    };

    function automatic logic [DW-1:0] vgen(int lane, logic [7:0] seed);
        return {seed, 8'(lane * 7 + 1), 8'(seed ^ 8'(lane)), 8'(lane)};
    endfunction

    function automatic logic [IW-1:0] igen(int lane, logic [1:0] p);
        case (p)
            2'd0: return 8'(31 - lane) | 8'hE0;
            2'd1: return 8'h47;
            2'd2: return 8'((lane * 5 + 3) % 32) + 8'(32 * (lane % 8));
            default: return 8'(lane);
        endcase
    endfunction

    // Reference model written from the requirements.
    function automatic logic [L*DW-1:0] model(logic [1:0] md, logic [5:0] op,
                                               logic [L*IW-1:0] idx, logic [L*DW-1:0] v);
        logic [L*DW-1:0] r;
        for (int i = 0; i < L; i++) begin
            int s;
            s = i;
            case (md)
                2'b00: s = int'(idx[i*IW +: 5]);
                2'b01: if (i - int'(op) >= 0) s = i - int'(op);
                2'b10: if (i + int'(op) <= 31) s = i + int'(op);
                default: s = i ^ int'(op[4:0]);
            endcase
            r[i*DW +: DW] = v[s*DW +: DW];
        end
        return r;
    endfunction

    task automatic check_vec(string req, logic [L*DW-1:0] act, logic [L*DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%b exp=%b", req, act, exp);
        end
    endtask

    function automatic string req_of(logic [1:0] md);
        case (md)
            2'b00: return "R2/R3 indexed";
            2'b01: return "R4 up";
            2'b10: return "R5 down";
            default: return "R6 butterfly";
        endcase
    endfunction

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [L*DW-1:0] exp_v, held;
        // R1: reset state
        repeat (3) @(negedge clk);
        check_bit("R1 valid_out", valid_out, 1'b0);
        check_vec("R1 values_out", values_out, '0);
        rst_n = 1'b1;

        // Table walk: R2..R7
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            mode = TBL[k].md;
            operand = TBL[k].op;
            for (int i = 0; i < L; i++) begin
                values_in[i*DW +: DW] = vgen(i, TBL[k].seed);
                lane_idx[i*IW +: IW] = igen(i, TBL[k].ipat);
            end
            valid_in = 1'b1;
            exp_v = model(mode, operand, lane_idx, values_in);
            @(negedge clk);
            valid_in = 1'b0;
            check_bit("R7 valid_out", valid_out, 1'b1);
            check_vec(req_of(TBL[k].md), values_out, exp_v);
        end

        // R7: valid drops one cycle after the strobe drops
        @(negedge clk);
        check_bit("R7 valid_out low", valid_out, 1'b0);

        // R8: inputs change with valid_in low; result holds
        held = values_out;
        mode = 2'b11; operand = 6'd9;
        for (int i = 0; i < L; i++) values_in[i*DW +: DW] = vgen(i, 8'h5A);
        @(negedge clk);
        @(negedge clk);
        check_vec("R8 hold", values_out, held);
        check_bit("R8 valid_out", valid_out, 1'b0);

        // R3: same low index bits, different upper bits, same result
        mode = 2'b00;
        for (int i = 0; i < L; i++) begin
            lane_idx[i*IW +: IW] = 8'(i ^ 3) | 8'hA0;
            values_in[i*DW +: DW] = vgen(i, 8'h3C);
        end
        exp_v = '0;
        for (int i = 0; i < L; i++) exp_v[i*DW +: DW] = vgen(i ^ 3, 8'h3C);
        valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
        check_vec("R3 upper index bits ignored", values_out, exp_v);

        // R7: back-to-back operations
        mode = 2'b01; operand = 6'd2; valid_in = 1'b1;
        exp_v = model(2'b01, 6'd2, lane_idx, values_in);
        @(negedge clk);
        check_vec("R7 back-to-back first", values_out, exp_v);
        mode = 2'b10; operand = 6'd2;
        exp_v = model(2'b10, 6'd2, lane_idx, values_in);
        @(negedge clk);
        valid_in = 1'b0;
        check_vec("R7 back-to-back second", values_out, exp_v);
        check_bit("R7 valid_out stays high", valid_out, 1'b1);

        // R1: reset in mid-run clears state
        rst_n = 1'b0;
        @(negedge clk);
        check_bit("R1 valid_out after reset", valid_out, 1'b0);
        check_vec("R1 values_out after reset", values_out, '0);
        rst_n = 1'b1;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule